// File: doc/BRIEF.md
# Interrupt Enable Configuration Register

This block holds an 8-bit read/write control byte that decides whether two event sources may interrupt the host. One bit enables all interrupts. Two bits enable the interface-error source and the address-match source separately. The top bit selects an operating mode and latches: software can set it but cannot clear it again. Only a hardware reset clears it. The register is written with a single-cycle strobe, and its current value is always present on the readback bus.

Two single-cycle event inputs each set a pending flag. A flag stays set until software clears it with a clear strobe and a bit mask. Which event set the flag does not matter to the clear. The interrupt pin is active low.
- When the global enable is 1, the pin is driven. It goes low while any enabled flag is pending and is high otherwise.
- When the global enable is 0, the pin is released to high impedance, and `irq_oe` shows this to the pad logic.
- Masking, whether global or per source, never clears a pending flag.

Top module: `cfgirq_ctrl`

## Requirements
- R1: After reset the readback is 0x00, both pending flags are clear and the interrupt pin is released (`irq_oe` = 0).
- R2: A write updates the register. From the next cycle the readback shows bit 6 (interface-error enable), bit 5 (address-match enable) and bit 4 (global enable) exactly as written.
- R3: Bits 3:0 ignore writes and always read as zero.
- R4: Bit 7 (mode) becomes 1 when written with 1. After that, writes of 0 leave it at 1 until the next reset, and a reset clears it.
- R5: A one-cycle pulse on `evt_iferr` or `evt_match` sets that source's pending flag. The flag stays set until `clr_en` is high with the matching `clr_mask` bit set (bit 0 = interface error, bit 1 = address match). A clear with the other mask bit set leaves the flag unchanged.
- R6: While the global enable is 0, `irq_oe` is 0 and the pin is undriven. Pending flags are kept, so setting the global enable later drives the pin low at once.
- R7: While the global enable is 1, `irq_oe` is 1. `irq_n` is 0 when at least one pending flag has its own enable bit set, and 1 otherwise.
- R8: A source whose own enable bit is 0 does not pull the pin low, but its pending flag is kept. Enabling the source later asserts the pin.
- R9: If an event and a clear of the same source arrive in the same cycle, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| evt_iferr | input | 1 | Interface-error event pulse |
| evt_match | input | 1 | Address-match event pulse |
| clr_en | input | 1 | Pending-flag clear strobe |
| clr_mask | input | 2 | Flags to clear: bit 0 interface error, bit 1 address match |
| irq_n | output | 1 | Active-low interrupt, high impedance when released |
| irq_oe | output | 1 | High while the interrupt pin is driven |

## Verification
Every result is due one cycle after its stimulus, counted as one register stage.
- A write shows on `rd_data` after the first rising edge.
- An event or a clear changes the pending flag on that same edge.
- The pin follows the flags and enables through logic only, with no further register.

The bench changes inputs on the falling edge and samples outputs on the next falling edge, half a period after the register has updated. It reads `irq_n` only while `irq_oe` is 1.

// File: rtl/cfgirq_pkg.sv
package cfgirq_pkg;
  localparam int CFG_W     = 8;
  localparam int NUM_SRC   = 2;

  localparam int BIT_MODE  = 7;
  localparam int BIT_ERR   = 6;
  localparam int BIT_MATCH = 5;
  localparam int BIT_GLOB  = 4;

  localparam int SRC_ERR   = 0;
  localparam int SRC_MATCH = 1;

  localparam logic [CFG_W-1:0] WR_MASK =
    CFG_W'((1 << BIT_MODE) | (1 << BIT_ERR) | (1 << BIT_MATCH) | (1 << BIT_GLOB));
  localparam logic [CFG_W-1:0] STICKY_MASK = CFG_W'(1 << BIT_MODE);

  typedef struct packed {
    logic mode;
    logic en_err;
    logic en_match;
    logic en_glob;
  } cfg_fields_t;
endpackage

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfgirq_pkg::*;
#(
  parameter int W = CFG_W,
  parameter logic [W-1:0] WMASK = WR_MASK,
  parameter logic [W-1:0] SMASK = STICKY_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg_q,
  output cfg_fields_t  fields
);
  logic [W-1:0] cfg_next;

  always_comb begin
    cfg_next = cfg_q;
    if (wr_en) begin
      // writable bits take the new value; latched bits can only be set
      cfg_next = (wr_data & WMASK) | (cfg_q & SMASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_next;
  end

  always_comb begin
    fields.mode     = cfg_q[BIT_MODE];
    fields.en_err   = cfg_q[BIT_ERR];
    fields.en_match = cfg_q[BIT_MATCH];
    fields.en_glob  = cfg_q[BIT_GLOB];
  end
endmodule

// File: rtl/pend_flags.sv
module pend_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend[g] <= 1'b0;
      else if (evt[g])                  pend[g] <= 1'b1;
      else if (clr_en && clr_mask[g])   pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N = 2
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] src_en,
  input  logic         glob_en,
  output logic         drv_level,
  output logic         drv_oe
);
  logic [N-1:0] live;
  assign live      = pend & src_en;
  assign drv_level = ~(|live);
  assign drv_oe    = glob_en;
endmodule

// File: rtl/cfgirq_ctrl.sv
module cfgirq_ctrl
  import cfgirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [CFG_W-1:0]   rd_data,
  input  logic               evt_iferr,
  input  logic               evt_match,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic               irq_n,
  output logic               irq_oe
);
  cfg_fields_t        fields;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] src_en;
  logic               drv_level;

  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_ERR]   = evt_iferr;
    evt_vec[SRC_MATCH] = evt_match;
    src_en             = '0;
    src_en[SRC_ERR]    = fields.en_err;
    src_en[SRC_MATCH]  = fields.en_match;
  end

  cfg_reg_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_q   (rd_data),
    .fields  (fields)
  );

  pend_flags #(.N(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_vec),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  irq_gate #(.N(NUM_SRC)) u_gate (
    .pend      (pend),
    .src_en    (src_en),
    .glob_en   (fields.en_glob),
    .drv_level (drv_level),
    .drv_oe    (irq_oe)
  );

  assign irq_n = irq_oe ? drv_level : 1'bz;
endmodule

// File: rtl/cfgirq_ctrl_chk.sv
module cfgirq_ctrl_chk
  import cfgirq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [CFG_W-1:0]   wr_data,
  input logic [CFG_W-1:0]   rd_data,
  input logic               evt_iferr,
  input logic               evt_match,
  input logic               clr_en,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic               irq_n,
  input logic               irq_oe
);
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[6:4] == $past(wr_data[6:4])); // R2

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'h0); // R3

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_MODE] |=> rd_data[BIT_MODE]); // R4

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[BIT_GLOB] |-> !irq_oe); // R6

  AST_EVENT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_iferr && rd_data[BIT_ERR] && rd_data[BIT_GLOB] && !wr_en)
      |=> (irq_oe && !irq_n)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_match && clr_en && clr_mask[SRC_MATCH] && rd_data[BIT_MATCH]
     && rd_data[BIT_GLOB] && !wr_en) |=> !irq_n); // R9
endmodule

bind cfgirq_ctrl cfgirq_ctrl_chk u_chk (.*);

// File: tb/cfgirq_ctrl_test.sv
`timescale 1ns/1ps
module cfgirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       evt_iferr = 1'b0;
  logic       evt_match = 1'b0;
  logic       clr_en = 1'b0;
  logic [1:0] clr_mask = 2'b00;
  logic       irq_n;
  logic       irq_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cfgirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_iferr(evt_iferr), .evt_match(evt_match),
    .clr_en(clr_en), .clr_mask(clr_mask), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input logic e, input logic m);
    evt_iferr = e; evt_match = m; step(); evt_iferr = 1'b0; evt_match = 1'b0;
  endtask

  task automatic clear(input logic [1:0] msk);
    clr_en = 1'b1; clr_mask = msk; step(); clr_en = 1'b0; clr_mask = 2'b00;
  endtask

  // driven pin: expect oe=1 and the given level
  task automatic pin_driven(input string req, input logic lvl);
    chk({req, " oe"}, int'(irq_oe), 1);
    if (irq_oe) chk({req, " level"}, int'(irq_n), int'(lvl));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 readback", int'(rd_data), 8'h00);
    chk("R1 released", int'(irq_oe), 0);
    write(8'h70);                       // enable all: pending must be clear
    pin_driven("R1 no pending", 1'b1);
  endtask

  task automatic t_readback();
    do_reset();
    write(8'h50); chk("R2 0x50", int'(rd_data), 8'h50);
    write(8'h20); chk("R2 0x20", int'(rd_data), 8'h20);
    write(8'h60); chk("R2 0x60", int'(rd_data), 8'h60);
  endtask

  task automatic t_unused();
    do_reset();
    write(8'h0F); chk("R3 low only", int'(rd_data), 8'h00);
    write(8'h7A); chk("R3 mixed", int'(rd_data), 8'h70);
  endtask

  task automatic t_sticky();
    do_reset();
    write(8'h80); chk("R4 set", int'(rd_data), 8'h80);
    write(8'h00); chk("R4 kept after 0", int'(rd_data), 8'h80);
    write(8'h30); chk("R4 kept with others", int'(rd_data), 8'hB0);
    do_reset();
    chk("R4 reset clears", int'(rd_data), 8'h00);
  endtask

  task automatic t_pending();
    do_reset();
    write(8'h70);
    pulse(1'b1, 1'b0); pin_driven("R5 err sets", 1'b0);
    step();            pin_driven("R5 err holds", 1'b0);
    clear(2'b10);      pin_driven("R5 wrong mask", 1'b0);
    clear(2'b01);      pin_driven("R5 err cleared", 1'b1);
    pulse(1'b0, 1'b1); pin_driven("R5 match sets", 1'b0);
    clear(2'b10);      pin_driven("R5 match cleared", 1'b1);
  endtask

  task automatic t_global();
    do_reset();
    write(8'h60);
    chk("R6 released", int'(irq_oe), 0);
    pulse(1'b1, 1'b0);
    chk("R6 still released", int'(irq_oe), 0);
    write(8'h70);      pin_driven("R6 kept pending", 1'b0);
    write(8'h60);      chk("R6 re-released", int'(irq_oe), 0);
  endtask

  task automatic t_drive();
    do_reset();
    write(8'h10);      pin_driven("R7 idle high", 1'b1);
    write(8'h30);
    pulse(1'b0, 1'b1); pin_driven("R7 low", 1'b0);
    pulse(1'b1, 1'b0); pin_driven("R7 both low", 1'b0);
    clear(2'b11);      pin_driven("R7 high again", 1'b1);
  endtask

  task automatic t_indiv();
    do_reset();
    write(8'h30);                         // match only enabled
    pulse(1'b1, 1'b0); pin_driven("R8 err masked", 1'b1);
    write(8'h70);      pin_driven("R8 err kept", 1'b0);
    clear(2'b01);      pin_driven("R8 cleared", 1'b1);
  endtask

  task automatic t_race();
    do_reset();
    write(8'h70);
    evt_iferr = 1'b1; clr_en = 1'b1; clr_mask = 2'b01; step();
    evt_iferr = 1'b0; clr_en = 1'b0; clr_mask = 2'b00;
    pin_driven("R9 set wins", 1'b0);
    step();
    pin_driven("R9 still set", 1'b0);
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_readback();
    t_unused();
    t_sticky();
    t_pending();
    t_global();
    t_drive();
    t_indiv();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule